// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This block holds two identical 16-bit counting channels behind one simple register bus. Each channel counts on single-cycle tick pulses taken from a clock source it selects. The sources are four taps of an internal prescaler, a rising edge of a slow clock line, or a rising edge of an external line. Each channel has three compare values. Compare matches set event flags, drive one waveform pin, and can end or restart the count. This lets one channel serve as a periodic tick, as a one-shot delay, or as a square-wave generator.

The second channel's external line is the first channel's waveform pin. With the first channel free-running and its pin set at count 0 and cleared at 0x8000, the second channel counts the upper half of a 32-bit time base. A block-wide sync write restarts both channels in the same cycle.

Each channel is a two-state machine. The states are STOPPED and RUNNING, with three named transitions:
- START (STOPPED to RUNNING) on an enable command, a trigger or a sync.
- HALT (RUNNING to STOPPED) on a disable command.
- ONESHOT_DONE (RUNNING to STOPPED) on an RC match while stop-on-RC is set.

Top module: `tmr_pair`

## Requirements
- R1: In free-run mode (MODE bits 3 and 4 both clear), a running counter advances by one per tick and wraps from 0xFFFF to 0. The tick taken at 0xFFFF sets the overflow flag, STAT bit 3.
- R2: In up-to-RC mode (MODE bit 3), the tick taken while the count equals RC returns the counter to 0, so the period is RC+1 ticks. That tick sets the RC flag, STAT bit 2. A tick taken while the count equals RA sets STAT bit 0, and one taken while it equals RB sets STAT bit 1.
- R3: With stop-on-RC (MODE bit 4), the RC-match tick returns the counter to 0 and stops it (ONESHOT_DONE). It then stays at 0 until a new trigger or sync.
- R4: A write to CTRL (register 0) acts on its bits. Bit 0 starts counting from the held value, with the first step on the tick after the write. Bit 1 stops counting and holds the value, and it wins over bit 0. Bit 2 clears the counter to 0 and starts it.
- R5: Writing ones to IEN (register 7) sets interrupt enable bits, and writing ones to IDIS (register 8) clears them; the two are applied as (mask OR IEN) AND NOT IDIS. IMASK (register 9) reads the four enable bits, and an IDIS write of 0xFF clears all of them.
- R6: STAT (register 6) reads the event flags in bits 3..0 and the running state in bit 8. A read clears the event flags at the next clock edge, and an event arriving in that same cycle is kept. After reset, STAT, CNT and IMASK read 0.
- R7: A channel's irq output is high whenever any event flag is set whose enable bit is also set. It stays high until STAT is read or the enable is cleared.
- R8: With MODE bit 5 set, the RA-match tick drives the waveform pin high. With MODE bit 6 set, the RC-match tick drives it low, and the low drive wins when both match on the same tick. A trigger or sync drives the pin low.
- R9: MODE bits 2..0 select the tick source. Values 0 to 3 pick prescaler taps that divide the system clock by 1, 4, 16 and 64. Value 4 picks a rising edge of slow_clk. Value 5 picks a rising edge of the channel's external line, which is ext_clk for channel 0 and channel 0's waveform pin for channel 1. In the chained setup, channel 1 advances once per channel 0 wrap.
- R10: A write to register 15 with either channel address clears both counters to 0 and starts both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | Slow clock line, sampled and edge-detected |
| ext_clk | input | 1 | External count line for channel 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (STAT reads have side effects) |
| bus_addr | input | 5 | Bit 4 selects the channel; bits 3..0 select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| wave_out | output | 2 | Waveform pin per channel |
| irq_out | output | 2 | Interrupt line per channel |

## Verification
The counting function is tried with three patterns:
- A one-shot with RC=10, read at counts 10 and 11. This tells an exact stop on the match tick apart from a stop one tick early or late, and from a counter that keeps running.
- A periodic run with RC=4, walked cycle by cycle. This tells the RC+1 period apart from an RC period or a missed wrap.
- A chained 32-bit run across more than one low-half wrap. This tells a correct carry into the upper channel apart from a missed carry or a double carry, and also shows the square wave's high and low halves.

Status is read twice after the one-shot, which separates read-clear from sticky flags. A disable followed by a plain enable separates holding the count from resetting it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_BITS = 4;

    localparam logic [REG_BITS-1:0] REG_CTRL  = 4'd0;
    localparam logic [REG_BITS-1:0] REG_MODE  = 4'd1;
    localparam logic [REG_BITS-1:0] REG_CNT   = 4'd2;
    localparam logic [REG_BITS-1:0] REG_RA    = 4'd3;
    localparam logic [REG_BITS-1:0] REG_RB    = 4'd4;
    localparam logic [REG_BITS-1:0] REG_RC    = 4'd5;
    localparam logic [REG_BITS-1:0] REG_STAT  = 4'd6;
    localparam logic [REG_BITS-1:0] REG_IEN   = 4'd7;
    localparam logic [REG_BITS-1:0] REG_IDIS  = 4'd8;
    localparam logic [REG_BITS-1:0] REG_IMASK = 4'd9;
    localparam logic [REG_BITS-1:0] REG_SYNC  = 4'd15;

    localparam logic [2:0] SEL_SLOW = 3'd4;
    localparam logic [2:0] SEL_EXT  = 3'd5;

    localparam int NUM_EV  = 4;
    localparam int EV_RA   = 0;
    localparam int EV_RB   = 1;
    localparam int EV_RC   = 2;
    localparam int EV_OVF  = 3;
    localparam int RUN_BIT = 8;

    typedef enum logic {
        CH_STOPPED,
        CH_RUNNING
    } ch_state_e;

    typedef struct packed {
        logic       clr_rc;
        logic       set_ra;
        logic       stop_rc;
        logic       upto_rc;
        logic [2:0] clk_sel;
    } mode_t;

    localparam int MODE_BITS = $bits(mode_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int TAPS      = 4,
    parameter int STEP_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_lvl,
    output logic [TAPS-1:0] tap_tick,
    output logic            slow_tick
);
    localparam int DIV_BITS = (TAPS - 1) * STEP_LOG2;

    logic [DIV_BITS-1:0] div_q;
    logic                slow_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            slow_q <= 1'b0;
        end else begin
            div_q  <= div_q + DIV_BITS'(1);
            slow_q <= slow_lvl;
        end
    end

    assign slow_tick = slow_lvl & ~slow_q;

    // Tap t fires once every 2^(t*STEP_LOG2) cycles.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        if (t == 0) begin : g_full
            assign tap_tick[t] = 1'b1;
        end else begin : g_div
            assign tap_tick[t] = &div_q[t*STEP_LOG2-1:0];
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W    = 16,
    parameter int TAPS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAPS-1:0]     tap_tick,
    input  logic                slow_tick,
    input  logic                ext_lvl,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [REG_BITS-1:0] reg_sel,
    input  logic [W-1:0]        wdata,
    input  logic                sync,
    output logic [W-1:0]        rdata,
    output logic                wave,
    output logic                irq,
    output logic                running,
    output logic [W-1:0]        cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    ch_state_e         state_q, state_d;
    mode_t             mode_q;
    logic [W-1:0]      ra_q, rb_q, rc_q;
    logic [NUM_EV-1:0] flags_q, mask_q, ev_hit, flag_clr;
    logic              ext_q, src_tick, tick, at_rc;
    logic              wr_ctrl, cmd_en, cmd_dis, cmd_trig, restart;

    assign wr_ctrl  = wr_en && (reg_sel == REG_CTRL);
    assign cmd_en   = wr_ctrl & wdata[0];
    assign cmd_dis  = wr_ctrl & wdata[1];
    assign cmd_trig = wr_ctrl & wdata[2];
    assign restart  = sync | cmd_trig;
    assign running  = (state_q == CH_RUNNING);

    always_comb begin
        src_tick = 1'b0;
        for (int t = 0; t < TAPS; t++) begin
            if (mode_q.clk_sel == 3'(t)) src_tick = tap_tick[t];
        end
        if (mode_q.clk_sel == SEL_SLOW) src_tick = slow_tick;
        if (mode_q.clk_sel == SEL_EXT)  src_tick = ext_lvl & ~ext_q;
    end

    assign tick   = running & src_tick & ~restart;
    assign at_rc  = (cnt == rc_q);
    assign ev_hit[EV_RA]  = tick & (cnt == ra_q);
    assign ev_hit[EV_RB]  = tick & (cnt == rb_q);
    assign ev_hit[EV_RC]  = tick & at_rc;
    assign ev_hit[EV_OVF] = tick & (cnt == CNT_MAX);
    assign flag_clr = (rd_en && (reg_sel == REG_STAT)) ? '1 : '0;

    // Next state: START, HALT, ONESHOT_DONE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: begin
                if (sync || ((cmd_en || cmd_trig) && !cmd_dis)) state_d = CH_RUNNING;
            end
            CH_RUNNING: begin
                if (cmd_dis && !sync)                       state_d = CH_STOPPED;
                else if (ev_hit[EV_RC] && mode_q.stop_rc)   state_d = CH_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            wave    <= 1'b0;
            flags_q <= '0;
            ext_q   <= 1'b0;
        end else begin
            ext_q   <= ext_lvl;
            flags_q <= (flags_q & ~flag_clr) | ev_hit;
            if (restart) begin
                cnt  <= '0;
                wave <= 1'b0;
            end else if (tick) begin
                cnt <= (at_rc && (mode_q.upto_rc || mode_q.stop_rc)) ? '0 : cnt + W'(1);
                if (ev_hit[EV_RC] && mode_q.clr_rc)      wave <= 1'b0;
                else if (ev_hit[EV_RA] && mode_q.set_ra) wave <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            rc_q   <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_MODE: mode_q <= mode_t'(wdata[MODE_BITS-1:0]);
                REG_RA:   ra_q   <= wdata;
                REG_RB:   rb_q   <= wdata;
                REG_RC:   rc_q   <= wdata;
                REG_IEN:  mask_q <= mask_q | wdata[NUM_EV-1:0];
                REG_IDIS: mask_q <= mask_q & ~wdata[NUM_EV-1:0];
                default:  ;
            endcase
        end
    end

    assign irq = |(flags_q & mask_q);

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            REG_MODE:  rdata = {{(W-MODE_BITS){1'b0}}, mode_q};
            REG_CNT:   rdata = cnt;
            REG_RA:    rdata = ra_q;
            REG_RB:    rdata = rb_q;
            REG_RC:    rdata = rc_q;
            REG_STAT: begin
                rdata[NUM_EV-1:0] = flags_q;
                rdata[RUN_BIT]    = running;
            end
            REG_IMASK: rdata = {{(W-NUM_EV){1'b0}}, mask_q};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W         = 16,
    parameter int NCH       = 2,
    parameter int TAPS      = 4,
    parameter int STEP_LOG2 = 2,
    localparam int CH_BITS  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW       = CH_BITS + REG_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slow_clk,
    input  logic           ext_clk,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    output logic [NCH-1:0] wave_out,
    output logic [NCH-1:0] irq_out
);
    logic [TAPS-1:0]         tap_tick;
    logic                    slow_tick, sync;
    logic [CH_BITS-1:0]      ch_idx;
    logic [NCH-1:0]          ext_vec, run_vec;
    logic [NCH-1:0][W-1:0]   cnt_vec, rdata_vec;

    assign sync   = bus_wr && (bus_addr[REG_BITS-1:0] == REG_SYNC);
    assign ch_idx = bus_addr[AW-1:REG_BITS];

    tmr_prescaler #(.TAPS(TAPS), .STEP_LOG2(STEP_LOG2)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_lvl (slow_clk),
        .tap_tick (tap_tick),
        .slow_tick(slow_tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = (ch_idx == CH_BITS'(c));
        if (c == 0) begin : g_first
            assign ext_vec[c] = ext_clk;
        end else begin : g_chain
            assign ext_vec[c] = wave_out[c-1];
        end

        tmr_channel #(.W(W), .TAPS(TAPS)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tap_tick (tap_tick),
            .slow_tick(slow_tick),
            .ext_lvl  (ext_vec[c]),
            .wr_en    (bus_wr & hit & ~sync),
            .rd_en    (bus_rd & hit),
            .reg_sel  (bus_addr[REG_BITS-1:0]),
            .wdata    (bus_wdata),
            .sync     (sync),
            .rdata    (rdata_vec[c]),
            .wave     (wave_out[c]),
            .irq      (irq_out[c]),
            .running  (run_vec[c]),
            .cnt      (cnt_vec[c])
        );
    end

    assign bus_rdata = rdata_vec[ch_idx];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 2,
    parameter int AW  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [NUM_EV-1:0]     wdata_lo,
    input logic [NCH-1:0]        irq_out,
    input logic [NCH-1:0][W-1:0] cnt_vec,
    input logic [NCH-1:0]        run_vec
);
    logic sync;
    assign sync = bus_wr && (bus_addr[REG_BITS-1:0] == REG_SYNC);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic ch_wr, ctrl_wr, idis_wr;
        assign ch_wr   = bus_wr && !sync && (int'(bus_addr[AW-1:REG_BITS]) == c);
        assign ctrl_wr = ch_wr && (bus_addr[REG_BITS-1:0] == REG_CTRL);
        assign idis_wr = ch_wr && (bus_addr[REG_BITS-1:0] == REG_IDIS);

        assert_sync_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
            sync |=> (cnt_vec[c] == '0) && run_vec[c]);

        assert_disable_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && wdata_lo[1]) |=> !run_vec[c]);

        assert_trigger_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && wdata_lo[2]) |=> (cnt_vec[c] == '0));

        assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (idis_wr && (wdata_lo == '1)) |=> !irq_out[c]);

        assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_vec[c] == $past(cnt_vec[c])) ||
                     (cnt_vec[c] == $past(cnt_vec[c]) + W'(1)) ||
                     (cnt_vec[c] == '0));

        assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[c] && !sync && !ch_wr) |=> $stable(cnt_vec[c]));
    end
endmodule

bind tmr_pair tmr_pair_chk #(.W(W), .NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[tmr_pkg::NUM_EV-1:0]),
    .irq_out  (irq_out),
    .cnt_vec  (cnt_vec),
    .run_vec  (run_vec)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        ext_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  wave_out, irq_out;

    int total = 0;
    int bad   = 0;
    logic [15:0] v1, v2, d;

    // Expected counts, one per cycle, for up-to-RC with RC=4 after a trigger.
    localparam logic [15:0] PERIOD_EXP [12] = '{
        16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd0,
        16'd1, 16'd2, 16'd3, 16'd4, 16'd0, 16'd1
    };

    localparam logic [4:0] C0 = 5'h00;
    localparam logic [4:0] C1 = 5'h10;

    tmr_pair uut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .ext_clk(ext_clk),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_out(wave_out), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] val);
        bus_addr = a; bus_wdata = val; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] val);
        bus_addr = a; bus_rd = 1'b1;
        #1 val = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input logic [4:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] got;
        rd(a, got);
        check(tag, {16'h0, got}, {16'h0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R6)
        rdchk(C0 | 5'd1, 16'h0000, "R6 reset MODE");
        rdchk(C0 | 5'd2, 16'h0000, "R6 reset CNT");
        rdchk(C0 | 5'd6, 16'h0000, "R6 reset STAT");
        rdchk(C0 | 5'd9, 16'h0000, "R6 reset IMASK");
        check("R8 reset wave", {30'h0, wave_out}, 32'h0);
        check("R7 reset irq", {30'h0, irq_out}, 32'h0);

        // Interrupt enable registers (R5)
        wr(C0 | 5'd7, 16'h000F);
        rdchk(C0 | 5'd9, 16'h000F, "R5 IEN sets");
        wr(C0 | 5'd8, 16'h0003);
        rdchk(C0 | 5'd9, 16'h000C, "R5 IDIS clears");
        wr(C0 | 5'd8, 16'h00FF);
        rdchk(C0 | 5'd9, 16'h0000, "R5 IDIS 0xFF clears all");

        // One-shot with RC=10 (R3, R6, R7)
        wr(C0 | 5'd5, 16'd10);
        wr(C0 | 5'd1, 16'h0018);
        wr(C0 | 5'd7, 16'h0004);
        wr(C0 | 5'd0, 16'h0005);
        idle(10);
        rdchk(C0 | 5'd2, 16'd10, "R3 count reaches RC");
        check("R7 irq on RC flag", {31'h0, irq_out[0]}, 32'h1);
        rdchk(C0 | 5'd6, 16'h0007, "R3 stopped with RA RB RC flags");
        check("R6 irq drops after status read", {31'h0, irq_out[0]}, 32'h0);
        rdchk(C0 | 5'd6, 16'h0000, "R6 flags cleared by read");
        idle(20);
        rdchk(C0 | 5'd2, 16'h0000, "R3 one-shot stays at zero");

        // Periodic up-to-RC with RC=4 (R2)
        wr(C0 | 5'd1, 16'h0008);
        wr(C0 | 5'd5, 16'd4);
        wr(C0 | 5'd8, 16'h00FF);
        rd(C0 | 5'd6, d);
        wr(C0 | 5'd0, 16'h0005);
        bus_addr = C0 | 5'd2;
        for (int i = 0; i < 12; i++) begin
            #1 check($sformatf("R2 periodic step %0d", i), {16'h0, bus_rdata}, {16'h0, PERIOD_EXP[i]});
            @(negedge clk);
        end
        rdchk(C0 | 5'd6, 16'h0107, "R2 RC flag while running");

        // Disable holds, enable resumes (R4)
        wr(C0 | 5'd0, 16'h0002);
        rd(C0 | 5'd6, d);
        check("R4 disable clears running", {16'h0, d & 16'h0100}, 32'h0);
        rd(C0 | 5'd2, v1);
        idle(5);
        rd(C0 | 5'd2, v2);
        check("R4 count held while stopped", {16'h0, v2}, {16'h0, v1});
        wr(C0 | 5'd0, 16'h0001);
        rdchk(C0 | 5'd2, v1, "R4 enable keeps value");
        rdchk(C0 | 5'd2, (v1 == 16'd4) ? 16'd0 : v1 + 16'd1, "R4 enable resumes counting");
        wr(C0 | 5'd0, 16'h0002);

        // Chained 32-bit count (R1, R8, R9, R10)
        wr(C0 | 5'd1, 16'h0060);
        wr(C0 | 5'd3, 16'h0000);
        wr(C0 | 5'd5, 16'h8000);
        wr(C1 | 5'd1, 16'h0005);
        rd(C0 | 5'd6, d);
        rd(C1 | 5'd6, d);
        wr(5'h0F, 16'h0000);
        idle(100);
        check("R8 wave high after RA", {31'h0, wave_out[0]}, 32'h1);
        rdchk(C0 | 5'd2, 16'd100, "R10 low half after sync");
        rdchk(C1 | 5'd2, 16'd1, "R9 upper half after first edge");
        idle(40000 - 102);
        check("R8 wave low after RC", {31'h0, wave_out[0]}, 32'h0);
        idle(65530 - 40000);
        rdchk(C1 | 5'd2, 16'd1, "R9 upper half before carry");
        idle(10);
        rdchk(C0 | 5'd2, 16'd5, "R1 low half wrapped");
        rdchk(C1 | 5'd2, 16'd2, "R9 upper half after carry");
        rdchk(C0 | 5'd6, 16'h010F, "R1 overflow flag");

        // Second sync restarts both together (R10)
        wr(5'h1F, 16'h0000);
        rdchk(C0 | 5'd2, 16'd0, "R10 low half restarted");
        rdchk(C1 | 5'd2, 16'd0, "R10 upper half restarted");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule